// File: doc/BRIEF.md
# Reset Sequencer with Cause Register

This block turns every reset request in a small controller into one timed reset. Requests come from a power-on detector, a low-voltage detector, a watchdog, the instruction decoder (illegal opcode) and the address decoder (illegal address). A request can also come from an external active-low reset pin, which the block senses through a synchroniser. All timing is counted on the crystal clock.

On an internal request the block pulls the pad low for a set number of cycles, so that parts on the board are reset too. It then holds the core reset for a further stretch. A power-on or low-voltage reset adds a long settling delay in front of the pad drive. An external pin reset holds the core in reset while the pin stays low, and then for the same stretch after the pin is released.

A status register records the cause of each reset. It clears on a read strobe. The block also supplies the address of the reset vector pair, which moves when the monitor-mode input is high. A free-running cycle counter restarts on internal requests but keeps running through an external pin reset.

Top module: `reset_sequencer`

## Requirements
- R1: `core_rst` is high whenever any reset phase is active, and it is high with `pin_pull_low` high while `por_rst` is asserted.
- R2: With `monitor_mode` low the vector pair is 0xFFFE (high byte) and 0xFFFF (low byte). With it high the pair is 0xFEFE and 0xFEFF.
- R3: A watchdog, illegal-opcode or illegal-address request sampled on a clock edge sets `pin_pull_low` for exactly DRIVE_CYCLES cycles (default 32), starting after that edge. `core_rst` stays high for DRIVE_CYCLES + STRETCH_CYCLES cycles (default 64).
- R4: After `por_rst` is released, `pin_pull_low` stays high for LONG_CYCLES + DRIVE_CYCLES cycles (default 4096 + 32). `core_rst` stays high for LONG_CYCLES + DRIVE_CYCLES + STRETCH_CYCLES cycles.
- R5: A low-voltage request runs the same long sequence: the pad is driven low for LONG_CYCLES + DRIVE_CYCLES cycles, starting after the edge that samples the request.
- R6: When the block is idle and the pin is held low externally for N cycles, `core_rst` is high for exactly N + STRETCH_CYCLES cycles, starting SYNC_STAGES + 1 edges after the pin falls.
- R7: Status bit 1 (pin cause) is set only if the pin is held low for at least DRIVE_CYCLES + STRETCH_CYCLES + 3 cycles (default 67). This threshold applies when no power-on or low-voltage reset is pending.
- R8: After a power-on or low-voltage reset, the pin must stay low for LONG_CYCLES + DRIVE_CYCLES + STRETCH_CYCLES + 3 cycles (default 4163) before bit 1 is set. For power-on, the count starts at the release of `por_rst`.
- R9: `cyc_count` reads 0 in the cycle after an internal request is sampled, and 0 in the cycle after `por_rst` is released. After that it rises by one each cycle. An external pin reset does not disturb it.
- R10: The status bits are: bit 0 power-on, bit 1 pin, bit 2 watchdog, bit 3 illegal opcode, bit 4 illegal address, bit 5 low voltage. Bits 7:6 read 0. Each source sets only its own bit, and set bits accumulate until a read.
- R11: A power-on reset leaves the status at exactly 0x01.
- R12: A `stat_rd` strobe clears every status bit on its clock edge. A cause that is set on the same edge survives the clear.
- R13: A new internal request during an active sequence restarts the sequence from its first phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Crystal clock that times every phase |
| por_rst | input | 1 | Asynchronous power-on detector output, active high |
| pin_in_n | input | 1 | Sensed level of the external reset pad, active low |
| req_lvd | input | 1 | Low-voltage detector request |
| req_wdog | input | 1 | Watchdog timeout request |
| req_ill_op | input | 1 | Illegal opcode request |
| req_ill_addr | input | 1 | Illegal address request |
| monitor_mode | input | 1 | Selects the monitor-mode vector pair |
| stat_rd | input | 1 | Status read strobe; clears the register |
| pin_pull_low | output | 1 | Open-drain pad pull-down enable |
| core_rst | output | 1 | Internal reset to every module |
| stat_q | output | STAT_W | Reset cause register |
| vec_hi_addr | output | VEC_W | Address of the vector high byte |
| vec_lo_addr | output | VEC_W | Address of the vector low byte |
| cyc_count | output | CYC_W | Free-running cycle counter |

## Verification
If a phase counter loads a wrong value, the length of the high window on `pin_pull_low` or `core_rst` changes. This appears within one sequence, which is at most LONG + DRIVE + STRETCH cycles. The pin-low counter or the long-origin flag cannot be observed directly. If either is wrong, bit 1 of `stat_q` appears one cycle too early or too late, so the bench sweeps hold lengths across the threshold in steps of one cycle. If the synchroniser depth is wrong, the start of `core_rst` after an external fall moves by the same number of cycles. If the status update is wrong, it shows on the clock edge after the request or read strobe.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;

   typedef enum logic [2:0] {
      PH_IDLE    = 3'd0,
      PH_LONG    = 3'd1,
      PH_DRIVE   = 3'd2,
      PH_STRETCH = 3'd3,
      PH_EXT     = 3'd4
   } phase_e;

   localparam int unsigned FLAG_N   = 6;
   localparam int unsigned F_POR    = 0;
   localparam int unsigned F_PIN    = 1;
   localparam int unsigned F_WDOG   = 2;
   localparam int unsigned F_ILLOP  = 3;
   localparam int unsigned F_ILLADR = 4;
   localparam int unsigned F_LVD    = 5;

endpackage

// File: rtl/rstseq_pin_sync.sv
module rstseq_pin_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic por_rst,
   input  logic pin_in_n,
   output logic pin_low_s
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("rstseq_pin_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain;

   // Clears to "pin low": the pad is pulled low while power-on is asserted.
   always_ff @(posedge clk or posedge por_rst) begin
      if (por_rst) chain <= '0;
      else         chain <= {chain[STAGES-2:0], pin_in_n};
   end

   assign pin_low_s = ~chain[STAGES-1];

endmodule

// File: rtl/rstseq_phase_fsm.sv
module rstseq_phase_fsm
   import rstseq_pkg::*;
#(
   parameter int unsigned LONG_CYCLES    = 4096,
   parameter int unsigned DRIVE_CYCLES   = 32,
   parameter int unsigned STRETCH_CYCLES = 32,
   parameter int unsigned CYC_W          = 12
) (
   input  logic             clk,
   input  logic             por_rst,
   input  logic             any_req,
   input  logic             long_req,
   input  logic             pin_low_s,
   output logic             pin_pull_low,
   output logic             core_rst,
   output logic [CYC_W-1:0] cyc_count
);

   localparam int unsigned MAX_DS = (DRIVE_CYCLES > STRETCH_CYCLES) ? DRIVE_CYCLES : STRETCH_CYCLES;
   localparam int unsigned MAX_PH = (LONG_CYCLES > MAX_DS) ? LONG_CYCLES : MAX_DS;
   localparam int unsigned PW     = $clog2(MAX_PH + 1);
   localparam logic [PW-1:0] LONG_M1    = PW'(LONG_CYCLES - 1);
   localparam logic [PW-1:0] DRIVE_M1   = PW'(DRIVE_CYCLES - 1);
   localparam logic [PW-1:0] STRETCH_M1 = PW'(STRETCH_CYCLES - 1);

   generate
      if (LONG_CYCLES < 1 || DRIVE_CYCLES < 1 || STRETCH_CYCLES < 1) begin : g_bad_len
         $error("rstseq_phase_fsm: every phase needs at least one cycle");
      end
   endgenerate

   phase_e        phase;
   logic [PW-1:0] left;

   always_ff @(posedge clk or posedge por_rst) begin
      if (por_rst) begin
         phase <= PH_LONG;
         left  <= LONG_M1;
      end else if (any_req) begin
         phase <= long_req ? PH_LONG : PH_DRIVE;
         left  <= long_req ? LONG_M1 : DRIVE_M1;
      end else begin
         unique case (phase)
            PH_LONG: begin
               if (left == '0) begin
                  phase <= PH_DRIVE;
                  left  <= DRIVE_M1;
               end else begin
                  left <= left - 1'b1;
               end
            end
            PH_DRIVE: begin
               if (left == '0) begin
                  phase <= PH_STRETCH;
                  left  <= STRETCH_M1;
               end else begin
                  left <= left - 1'b1;
               end
            end
            PH_STRETCH: begin
               if (left == '0) phase <= PH_IDLE;
               else            left  <= left - 1'b1;
            end
            PH_EXT: begin
               if (!pin_low_s) begin
                  phase <= PH_STRETCH;
                  left  <= STRETCH_M1;
               end
            end
            default: begin
               if (pin_low_s) phase <= PH_EXT;
            end
         endcase
      end
   end

   assign pin_pull_low = (phase == PH_LONG) || (phase == PH_DRIVE);
   assign core_rst     = (phase != PH_IDLE);

   always_ff @(posedge clk or posedge por_rst) begin
      if (por_rst)      cyc_count <= '0;
      else if (any_req) cyc_count <= '0;
      else              cyc_count <= cyc_count + 1'b1;
   end

   // Checker state: length of the current pad-drive run since the last request.
   localparam int unsigned RUN_MAX = LONG_CYCLES + DRIVE_CYCLES + 1;
   localparam int unsigned RW      = $clog2(RUN_MAX + 1);
   localparam logic [RW-1:0] RUN_LIM = RW'(LONG_CYCLES + DRIVE_CYCLES);
   localparam logic [RW-1:0] RUN_TOP = RW'(RUN_MAX);
   logic [RW-1:0] drive_run;

   always_ff @(posedge clk or posedge por_rst) begin
      if (por_rst)                             drive_run <= '0;
      else if (any_req || !pin_pull_low)       drive_run <= '0;
      else if (drive_run != RUN_TOP)           drive_run <= drive_run + 1'b1;
   end

   assert_drive_bounded_R4: assert property (@(posedge clk) disable iff (por_rst)
      drive_run <= RUN_LIM);

   assert_pull_inside_rst_R1: assert property (@(posedge clk) disable iff (por_rst)
      pin_pull_low |-> core_rst);

   assert_restart_R13: assert property (@(posedge clk) disable iff (por_rst)
      any_req |=> (pin_pull_low && core_rst));

   assert_cycle_clear_R9: assert property (@(posedge clk) disable iff (por_rst)
      any_req |=> (cyc_count == '0));

endmodule

// File: rtl/rstseq_pin_watch.sv
module rstseq_pin_watch #(
   parameter int unsigned LONG_CYCLES    = 4096,
   parameter int unsigned DRIVE_CYCLES   = 32,
   parameter int unsigned STRETCH_CYCLES = 32,
   parameter int unsigned SYNC_STAGES    = 2,
   parameter int unsigned MARGIN         = 3
) (
   input  logic clk,
   input  logic por_rst,
   input  logic pin_low_s,
   input  logic pin_pull_low,
   input  logic long_trig,
   output logic pin_set
);

   localparam int unsigned SHORT_THR = DRIVE_CYCLES + STRETCH_CYCLES + MARGIN;
   localparam int unsigned LONG_THR  = LONG_CYCLES + SHORT_THR + SYNC_STAGES;
   localparam int unsigned CW        = $clog2(LONG_THR + 1);
   localparam logic [CW-1:0] SHORT_M1 = CW'(SHORT_THR - 1);
   localparam logic [CW-1:0] LONG_M1  = CW'(LONG_THR - 1);
   localparam logic [CW-1:0] CNT_TOP  = CW'(LONG_THR);

   logic [CW-1:0] low_cnt;
   logic          long_origin;

   always_ff @(posedge clk or posedge por_rst) begin
      if (por_rst)                low_cnt <= '0;
      else if (!pin_low_s)        low_cnt <= '0;
      else if (low_cnt != CNT_TOP) low_cnt <= low_cnt + 1'b1;
   end

   // Held until the pad is both released by the block and sensed high again.
   always_ff @(posedge clk or posedge por_rst) begin
      if (por_rst)                            long_origin <= 1'b1;
      else if (long_trig)                     long_origin <= 1'b1;
      else if (!pin_low_s && !pin_pull_low)   long_origin <= 1'b0;
   end

   assign pin_set = pin_low_s && (low_cnt >= (long_origin ? LONG_M1 : SHORT_M1));

   assert_pin_set_after_low_R7: assert property (@(posedge clk) disable iff (por_rst)
      $rose(pin_set) |-> $past(pin_low_s));

endmodule

// File: rtl/rstseq_status.sv
module rstseq_status
   import rstseq_pkg::*;
#(
   parameter int unsigned STAT_W = 8
) (
   input  logic              clk,
   input  logic              por_rst,
   input  logic              rd,
   input  logic              set_lvd,
   input  logic              set_wdog,
   input  logic              set_illop,
   input  logic              set_illadr,
   input  logic              set_pin,
   output logic [STAT_W-1:0] stat_q
);

   generate
      if (STAT_W < FLAG_N) begin : g_bad_width
         $error("rstseq_status: STAT_W too narrow for the cause flags");
      end
   endgenerate

   logic [FLAG_N-1:0] flags;
   logic [FLAG_N-1:0] set_vec;

   always_comb begin
      set_vec           = '0;
      set_vec[F_PIN]    = set_pin;
      set_vec[F_WDOG]   = set_wdog;
      set_vec[F_ILLOP]  = set_illop;
      set_vec[F_ILLADR] = set_illadr;
      set_vec[F_LVD]    = set_lvd;
   end

   always_ff @(posedge clk or posedge por_rst) begin
      if (por_rst) flags <= FLAG_N'(1) << F_POR;
      else         flags <= (rd ? '0 : flags) | set_vec;
   end

   assign stat_q = STAT_W'(flags);

   assert_wdog_sets_R10: assert property (@(posedge clk) disable iff (por_rst)
      set_wdog |=> stat_q[F_WDOG]);

   assert_read_clears_R12: assert property (@(posedge clk) disable iff (por_rst)
      (rd && set_vec == '0) |=> (stat_q == '0));

endmodule

// File: rtl/reset_sequencer.sv
module reset_sequencer
   import rstseq_pkg::*;
#(
   parameter int unsigned LONG_CYCLES    = 4096,
   parameter int unsigned DRIVE_CYCLES   = 32,
   parameter int unsigned STRETCH_CYCLES = 32,
   parameter int unsigned SYNC_STAGES    = 2,
   parameter int unsigned PIN_MARGIN     = 3,
   parameter int unsigned CYC_W          = 12,
   parameter int unsigned STAT_W         = 8,
   parameter int unsigned VEC_W          = 16,
   parameter logic [VEC_W-1:0] VEC_NORMAL  = 16'hFFFE,
   parameter logic [VEC_W-1:0] VEC_MONITOR = 16'hFEFE
) (
   input  logic              clk,
   input  logic              por_rst,
   input  logic              pin_in_n,
   input  logic              req_lvd,
   input  logic              req_wdog,
   input  logic              req_ill_op,
   input  logic              req_ill_addr,
   input  logic              monitor_mode,
   input  logic              stat_rd,
   output logic              pin_pull_low,
   output logic              core_rst,
   output logic [STAT_W-1:0] stat_q,
   output logic [VEC_W-1:0]  vec_hi_addr,
   output logic [VEC_W-1:0]  vec_lo_addr,
   output logic [CYC_W-1:0]  cyc_count
);

   generate
      if (VEC_NORMAL[0] || VEC_MONITOR[0]) begin : g_bad_vec
         $error("reset_sequencer: vector pair bases must be even");
      end
   endgenerate

   logic pin_low_s;
   logic any_req;
   logic pin_set;

   assign any_req = req_lvd | req_wdog | req_ill_op | req_ill_addr;

   rstseq_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk       (clk),
      .por_rst   (por_rst),
      .pin_in_n  (pin_in_n),
      .pin_low_s (pin_low_s)
   );

   rstseq_phase_fsm #(
      .LONG_CYCLES    (LONG_CYCLES),
      .DRIVE_CYCLES   (DRIVE_CYCLES),
      .STRETCH_CYCLES (STRETCH_CYCLES),
      .CYC_W          (CYC_W)
   ) u_fsm (
      .clk          (clk),
      .por_rst      (por_rst),
      .any_req      (any_req),
      .long_req     (req_lvd),
      .pin_low_s    (pin_low_s),
      .pin_pull_low (pin_pull_low),
      .core_rst     (core_rst),
      .cyc_count    (cyc_count)
   );

   rstseq_pin_watch #(
      .LONG_CYCLES    (LONG_CYCLES),
      .DRIVE_CYCLES   (DRIVE_CYCLES),
      .STRETCH_CYCLES (STRETCH_CYCLES),
      .SYNC_STAGES    (SYNC_STAGES),
      .MARGIN         (PIN_MARGIN)
   ) u_watch (
      .clk          (clk),
      .por_rst      (por_rst),
      .pin_low_s    (pin_low_s),
      .pin_pull_low (pin_pull_low),
      .long_trig    (req_lvd),
      .pin_set      (pin_set)
   );

   rstseq_status #(.STAT_W(STAT_W)) u_status (
      .clk        (clk),
      .por_rst    (por_rst),
      .rd         (stat_rd),
      .set_lvd    (req_lvd),
      .set_wdog   (req_wdog),
      .set_illop  (req_ill_op),
      .set_illadr (req_ill_addr),
      .set_pin    (pin_set),
      .stat_q     (stat_q)
   );

   assign vec_hi_addr = monitor_mode ? VEC_MONITOR : VEC_NORMAL;
   assign vec_lo_addr = vec_hi_addr + VEC_W'(1);

   assert_vec_pair_R2: assert property (@(posedge clk) disable iff (por_rst)
      (vec_lo_addr == vec_hi_addr + VEC_W'(1)) && !vec_hi_addr[0]);

   assert_read_port_R12: assert property (@(posedge clk) disable iff (por_rst)
      (stat_rd && !any_req && !pin_set) |=> (stat_q == '0));

   assert_req_holds_rst_R1: assert property (@(posedge clk) disable iff (por_rst)
      any_req |=> core_rst);

endmodule

// File: tb/reset_sequencer_tb.sv
module reset_sequencer_tb;

   localparam int L = 16;
   localparam int D = 4;
   localparam int S = 4;
   localparam int SHORT_MIN = D + S + 3;
   localparam int LONG_MIN  = L + D + S + 3;

   localparam int K_NONE = 0, K_POR = 1, K_EXT = 2, K_WDOG = 3, K_ILLOP = 4,
                  K_ILLADR = 5, K_LVD = 6, K_RESTART = 7, K_PORX = 8;

   logic clk = 1'b0;
   logic por_rst = 1'b1;
   logic ext_low = 1'b0;
   logic req_lvd = 1'b0, req_wdog = 1'b0, req_ill_op = 1'b0, req_ill_addr = 1'b0;
   logic monitor_mode = 1'b0, stat_rd = 1'b0;
   logic pin_in_n;
   logic pin_pull_low, core_rst;
   logic [7:0]  stat_q;
   logic [15:0] vec_hi_addr, vec_lo_addr;
   logic [11:0] cyc_count;

   int checks = 0;
   int errors = 0;
   int pin_hi, rst_hi;
   logic [11:0] cyc_first, cyc_last;

   always #4 clk = ~clk;

   assign pin_in_n = ~(pin_pull_low | ext_low);

   reset_sequencer #(
      .LONG_CYCLES(L), .DRIVE_CYCLES(D), .STRETCH_CYCLES(S),
      .SYNC_STAGES(2), .PIN_MARGIN(3), .CYC_W(12)
   ) u_dut (
      .clk(clk), .por_rst(por_rst), .pin_in_n(pin_in_n),
      .req_lvd(req_lvd), .req_wdog(req_wdog), .req_ill_op(req_ill_op),
      .req_ill_addr(req_ill_addr), .monitor_mode(monitor_mode), .stat_rd(stat_rd),
      .pin_pull_low(pin_pull_low), .core_rst(core_rst), .stat_q(stat_q),
      .vec_hi_addr(vec_hi_addr), .vec_lo_addr(vec_lo_addr), .cyc_count(cyc_count)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic window(input int w, input int kind, input int n);
      pin_hi = 0;
      rst_hi = 0;
      for (int i = 0; i < w; i++) begin
         @(negedge clk);
         pin_hi += int'(pin_pull_low);
         rst_hi += int'(core_rst);
         if (i == 0)     cyc_first = cyc_count;
         if (i == w - 1) cyc_last  = cyc_count;
         case (kind)
            K_POR:     if (i == 0) por_rst = 1'b0;
            K_EXT:     begin if (i == 0) ext_low = 1'b1; if (i == n) ext_low = 1'b0; end
            K_PORX:    begin if (i == 0) por_rst = 1'b0; if (i == n) ext_low = 1'b0; end
            K_WDOG:    req_wdog     = (i == 0);
            K_ILLOP:   req_ill_op   = (i == 0);
            K_ILLADR:  req_ill_addr = (i == 0);
            K_LVD:     req_lvd      = (i == 0);
            K_RESTART: begin req_wdog = (i == 0); req_ill_op = (i == 2); end
            default: ;
         endcase
      end
   endtask

   task automatic read_clear();
      @(negedge clk);
      stat_rd = 1'b1;
      @(negedge clk);
      stat_rd = 1'b0;
      check("R12 read clears", 32'(stat_q), 32'h00);
   endtask

   initial begin
      #1_600_000;
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R1 por core_rst", 32'(core_rst), 32'h1);
      check("R1 por pull", 32'(pin_pull_low), 32'h1);
      check("R11 por status", 32'(stat_q), 32'h01);

      window(60, K_POR, 0);
      check("R4 por pull cycles", 32'(pin_hi), 32'(L + D));
      check("R4 por rst cycles", 32'(rst_hi), 32'(L + D + S));
      check("R11 status after por", 32'(stat_q), 32'h01);
      check("R9 counter after por", 32'(cyc_last), 32'(59));
      read_clear();

      for (int m = 0; m < 2; m++) begin
         monitor_mode = m[0];
         #1;
         check("R2 vector high", 32'(vec_hi_addr), m ? 32'hFEFE : 32'hFFFE);
         check("R2 vector low", 32'(vec_lo_addr), m ? 32'hFEFF : 32'hFFFF);
      end
      monitor_mode = 1'b0;

      window(30, K_WDOG, 0);
      check("R3 wdog pull", 32'(pin_hi), 32'(D));
      check("R3 wdog rst", 32'(rst_hi), 32'(D + S));
      check("R10 wdog bit", 32'(stat_q), 32'h04);
      check("R9 counter cleared", 32'(cyc_last), 32'(28));

      window(30, K_ILLOP, 0);
      check("R3 illop rst", 32'(rst_hi), 32'(D + S));
      check("R10 bits accumulate", 32'(stat_q), 32'h0C);
      read_clear();

      window(30, K_ILLADR, 0);
      check("R3 illaddr pull", 32'(pin_hi), 32'(D));
      check("R10 illaddr bit", 32'(stat_q), 32'h10);
      read_clear();

      window(60, K_LVD, 0);
      check("R5 lvd pull", 32'(pin_hi), 32'(L + D));
      check("R5 lvd rst", 32'(rst_hi), 32'(L + D + S));
      check("R10 lvd bit", 32'(stat_q), 32'h20);
      read_clear();

      window(40, K_RESTART, 0);
      check("R13 restart pull", 32'(pin_hi), 32'(2 + D));
      check("R13 restart rst", 32'(rst_hi), 32'(2 + D + S));
      check("R13 restart bits", 32'(stat_q), 32'h0C);
      read_clear();

      for (int n = 1; n <= SHORT_MIN + 2; n++) begin
         window(n + S + 20, K_EXT, n);
         check("R6 ext rst cycles", 32'(rst_hi), 32'(n + S));
         check("R7 pin bit", 32'(stat_q), (n >= SHORT_MIN) ? 32'h02 : 32'h00);
         check("R9 counter runs through ext", 32'(12'(cyc_last - cyc_first)), 32'(n + S + 19));
         read_clear();
      end

      @(negedge clk);
      stat_rd  = 1'b1;
      req_wdog = 1'b1;
      @(negedge clk);
      stat_rd  = 1'b0;
      req_wdog = 1'b0;
      check("R12 set beats clear", 32'(stat_q), 32'h04);
      window(30, K_NONE, 0);
      read_clear();

      for (int k = 0; k < 2; k++) begin
         @(negedge clk);
         por_rst = 1'b1;
         ext_low = 1'b1;
         repeat (3) @(negedge clk);
         window(80, K_PORX, LONG_MIN - 1 + k);
         check("R8 long pin threshold", 32'(stat_q), k ? 32'h03 : 32'h01);
      end

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule